// File: doc/BRIEF.md
# Branch Decision and Target Unit

This unit looks at one 16-bit instruction word per clock and decides whether the word redirects the program counter. It recognises four branch families: short conditional branches tested against the processor status flags, short unconditional branches, a two-word long branch that also writes a return address to the link register, and the software trap that vectors to a fixed handler address. For every accepted word it produces a registered one-cycle result on the following clock: a taken strobe with the target address, an optional link write, a trap-entry strobe and a sequencing error strobe.

The unit keeps one piece of state: the partial target built by the first word of a long branch, which the next accepted word either completes or discards. Everything else is decided from the current word, its address and the flags. Fetch, pipeline flushing and the mode switch itself lie outside; the trap strobe is the only hint given to the mode logic.

Top module: `branch_unit`

## Requirements
- R1: While reset is asserted and on the first clock after it, `br_take`, `link_we`, `svc_enter` and `pair_err` are 0 and no long-branch first word is pending.
- R2: A word with bits [15:12]=1101 and condition field c=[11:8] in 0..7 is taken when, with `flags`={N,Z,C,V} in bits 3..0: c=0 Z=1, c=1 Z=0, c=2 C=1, c=3 C=0, c=4 N=1, c=5 N=0, c=6 V=1, c=7 V=0.
- R3: Condition c=8 is taken when C=1 and Z=0; c=9 when C=0 or Z=1; c=10 when N=V; c=11 when N!=V; c=12 when Z=0 and N=V; c=13 when Z=1 or N!=V.
- R4: A taken conditional branch gives `br_target` = address + 4 + (sign-extended bits [7:0]) * 2, with `br_take` high for exactly the one cycle after the word is accepted.
- R5: Condition c=14 is never taken, whatever the flags.
- R6: A word with bits [15:11]=11100 is always taken, target = address + 4 + (sign-extended bits [10:0]) * 2.
- R7: The word with bits [15:8]=11011111 is taken to address 0x00000008 and pulses `svc_enter` in the same cycle, without a link write.
- R8: A first word with bits [15:11]=11110 at address A produces no output; if the next accepted word has bits [15:11]=11111 at address B, the branch is taken to A + 4 + (sign-extended first bits [10:0]) * 4096 + (second bits [10:0]) * 2, and `link_we` pulses with `link_data` = B + 2 with bit 0 set.
- R9: A second long-branch word (bits [15:11]=11111) that is not the next accepted word after a first word is ignored: no taken strobe, no link write, and `pair_err` pulses for one cycle.
- R10: Any accepted word that is not a branch, and any cycle with `instr_valid` low, produces no strobe; a non-branch or other accepted word between the two long-branch words cancels the pending first word, while cycles with `instr_valid` low leave it pending.
- R11: When two first words arrive in a row, the later one is the one completed by the following second word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | The instruction word is to be evaluated this cycle |
| instr | input | 16 | Instruction word |
| instr_addr | input | AW | Address of the instruction word |
| flags | input | 4 | Status flags {N,Z,C,V} |
| br_take | output | 1 | Redirect strobe, one cycle |
| br_target | output | AW | Redirect address, meaningful while `br_take` is high |
| link_we | output | 1 | Link register write strobe |
| link_data | output | AW | Return address to write to the link register |
| svc_enter | output | 1 | Trap entry strobe toward the mode logic |
| pair_err | output | 1 | Long-branch second word arrived without its first word |

## Verification
The hardest situation to reach is the long-branch pairing rule, because whether a second word completes a branch depends on what the unit accepted before it rather than on anything visible at the ports in that cycle. The stimulus therefore builds deliberate sequences: a clean pair, a pair split by idle cycles, a pair split by an unrelated instruction, a second word straight after reset, and two first words back to back before one second word. The condition logic is swept across all fourteen codes under a set of flag patterns chosen so every flag combination the compound conditions care about appears.

// File: rtl/branch_unit.sv
module branch_unit #(
  parameter int AW = 32,
  parameter logic [AW-1:0] SVC_VECTOR = 'h8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          instr_valid,
  input  logic [15:0]   instr,
  input  logic [AW-1:0] instr_addr,
  input  logic [3:0]    flags,
  output logic          br_take,
  output logic [AW-1:0] br_target,
  output logic          link_we,
  output logic [AW-1:0] link_data,
  output logic          svc_enter,
  output logic          pair_err
);

  localparam logic [AW-1:0] STEP_NEXT = AW'(4);
  localparam logic [AW-1:0] STEP_HALF = AW'(2);

  logic fn, fz, fc, fv;
  assign {fn, fz, fc, fv} = flags;

  logic is_cond, is_svc, is_jump, is_hi, is_lo;
  assign is_svc  = instr[15:8] == 8'hDF;
  assign is_cond = instr[15:12] == 4'hD && !is_svc;
  assign is_jump = instr[15:11] == 5'b11100;
  assign is_hi   = instr[15:11] == 5'b11110;
  assign is_lo   = instr[15:11] == 5'b11111;

  logic cond_ok;
  always_comb begin
    case (instr[11:8])
      4'h0: cond_ok = fz;
      4'h1: cond_ok = !fz;
      4'h2: cond_ok = fc;
      4'h3: cond_ok = !fc;
      4'h4: cond_ok = fn;
      4'h5: cond_ok = !fn;
      4'h6: cond_ok = fv;
      4'h7: cond_ok = !fv;
      4'h8: cond_ok = fc && !fz;
      4'h9: cond_ok = !fc || fz;
      4'hA: cond_ok = fn == fv;
      4'hB: cond_ok = fn != fv;
      4'hC: cond_ok = !fz && (fn == fv);
      4'hD: cond_ok = fz || (fn != fv);
      default: cond_ok = 1'b0;
    endcase
  end

  logic [AW-1:0] ahead, off_short, off_long, off_upper, off_lower;
  assign ahead     = instr_addr + STEP_NEXT;
  assign off_short = {{(AW-9){instr[7]}}, instr[7:0], 1'b0};
  assign off_long  = {{(AW-12){instr[10]}}, instr[10:0], 1'b0};
  assign off_upper = {{(AW-23){instr[10]}}, instr[10:0], 12'b0};
  assign off_lower = {{(AW-12){1'b0}}, instr[10:0], 1'b0};

  logic          pend;
  logic [AW-1:0] pend_base;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_base <= '0;
      br_take   <= 1'b0;
      br_target <= '0;
      link_we   <= 1'b0;
      link_data <= '0;
      svc_enter <= 1'b0;
      pair_err  <= 1'b0;
    end else begin
      br_take   <= 1'b0;
      link_we   <= 1'b0;
      svc_enter <= 1'b0;
      pair_err  <= 1'b0;
      if (instr_valid) begin
        pend <= is_hi;
        if (is_hi) pend_base <= ahead + off_upper;
        if (is_cond && cond_ok) begin
          br_take   <= 1'b1;
          br_target <= ahead + off_short;
        end
        if (is_jump) begin
          br_take   <= 1'b1;
          br_target <= ahead + off_long;
        end
        if (is_svc) begin
          br_take   <= 1'b1;
          br_target <= SVC_VECTOR;
          svc_enter <= 1'b1;
        end
        if (is_lo) begin
          if (pend) begin
            br_take   <= 1'b1;
            br_target <= pend_base + off_lower;
            link_we   <= 1'b1;
            link_data <= (instr_addr + STEP_HALF) | AW'(1);
          end else begin
            pair_err  <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/branch_unit_chk.sv
module branch_unit_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          instr_valid,
  input logic [15:0]   instr,
  input logic [AW-1:0] br_target,
  input logic          br_take,
  input logic          link_we,
  input logic [AW-1:0] link_data,
  input logic          svc_enter,
  input logic          pair_err
);

  p_link_with_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> br_take);

  p_link_odd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> link_data[0]);

  p_svc_vector_r7: assert property (@(posedge clk) disable iff (!rst_n)
    svc_enter |-> (br_take && !link_we && br_target == AW'(8)));

  p_orphan_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pair_err |-> (!br_take && !link_we));

  p_never_cond14_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && instr[15:8] == 8'hDE) |=> !br_take);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> !(br_take || link_we || svc_enter || pair_err));

  p_single_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (br_take && !instr_valid) |=> !br_take);

endmodule

bind branch_unit branch_unit_chk #(.AW(AW)) u_chk (.*);

// File: tb/branch_unit_bench.sv
`timescale 1ns/1ps
module branch_unit_bench;
  localparam int AW = 32;

  typedef struct {
    logic          take;
    logic [AW-1:0] target;
    logic          lwe;
    logic [AW-1:0] link;
    logic          svc;
    logic          err;
    string         req;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          instr_valid = 1'b0;
  logic [15:0]   instr = '0;
  logic [AW-1:0] instr_addr = '0;
  logic [3:0]    flags = '0;
  logic          br_take, link_we, svc_enter, pair_err;
  logic [AW-1:0] br_target, link_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t q[$];

  bit            m_pend = 0;
  logic [AW-1:0] m_base = '0;

  always #4 clk = ~clk;

  branch_unit #(.AW(AW)) u_branch_unit (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .instr_addr(instr_addr), .flags(flags), .br_take(br_take),
    .br_target(br_target), .link_we(link_we), .link_data(link_data),
    .svc_enter(svc_enter), .pair_err(pair_err)
  );

  function automatic bit cond_true(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'd0: return z;          4'd1: return !z;
      4'd2: return cy;         4'd3: return !cy;
      4'd4: return n;          4'd5: return !n;
      4'd6: return v;          4'd7: return !v;
      4'd8: return cy && !z;   4'd9: return !cy || z;
      4'd10: return n == v;    4'd11: return n != v;
      4'd12: return !z && n == v;
      4'd13: return z || n != v;
      default: return 0;
    endcase
  endfunction

  task automatic step(input bit vld, input logic [15:0] w, input logic [AW-1:0] a,
                      input logic [3:0] f, input string req);
    exp_t e;
    logic [AW-1:0] s8, s11;
    e.take = 0; e.target = '0; e.lwe = 0; e.link = '0; e.svc = 0; e.err = 0; e.req = req;
    s8  = AW'(signed'(w[7:0])) * 2;
    s11 = AW'(signed'(w[10:0])) * 2;
    if (vld) begin
      if (w[15:8] == 8'hDF) begin
        e.take = 1; e.svc = 1; e.target = 8;
      end else if (w[15:12] == 4'hD) begin
        e.take = cond_true(w[11:8], f);
        e.target = a + 4 + s8;
      end else if (w[15:11] == 5'b11100) begin
        e.take = 1; e.target = a + 4 + s11;
      end else if (w[15:11] == 5'b11111) begin
        if (m_pend) begin
          e.take = 1; e.lwe = 1;
          e.target = m_base + AW'({w[10:0], 1'b0});
          e.link = (a + 2) | 1;
        end else e.err = 1;
      end
      if (w[15:11] == 5'b11110) m_base = a + 4 + (AW'(signed'(w[10:0])) << 12);
      m_pend = (w[15:11] == 5'b11110);
    end
    @(negedge clk);
    instr_valid = vld; instr = w; instr_addr = a; flags = f;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (br_take !== e.take || link_we !== e.lwe || svc_enter !== e.svc ||
            pair_err !== e.err || (e.take && br_target !== e.target) ||
            (e.lwe && link_data !== e.link)) begin
          errors++;
          $display("FAIL %s: take=%0b tgt=%h lwe=%0b link=%h svc=%0b err=%0b expected take=%0b tgt=%h lwe=%0b link=%h svc=%0b err=%0b",
                   e.req, br_take, br_target, link_we, link_data, svc_enter, pair_err,
                   e.take, e.target, e.lwe, e.link, e.svc, e.err);
        end
      end
    end
  end

  initial begin : watchdog
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    logic [3:0] pats [8] = '{4'b0000, 4'b0100, 4'b0010, 4'b1001, 4'b1000, 4'b0001, 4'b0110, 4'b1111};
    repeat (3) @(negedge clk);
    checks++;
    if (br_take !== 0 || link_we !== 0 || svc_enter !== 0 || pair_err !== 0) begin
      errors++;
      $display("FAIL R1: strobes=%b expected 0000", {br_take, link_we, svc_enter, pair_err});
    end
    rst_n = 1'b1;
    step(0, 16'h0000, '0, 4'h0, "R1");
    // R9 right after reset: nothing pending
    step(1, 16'hF812, 32'h100, 4'h0, "R1 R9");
    // R2 R3 R4 sweep
    for (int p = 0; p < 8; p++)
      for (int c = 0; c < 14; c++)
        step(1, {4'hD, 4'(c), 8'(c * 37 + p * 11)}, 32'h1000 + 32'(p * 64 + c * 2),
             pats[p], c < 8 ? "R2 R4" : "R3 R4");
    // R5
    for (int p = 0; p < 8; p++) step(1, 16'hDE05, 32'h2000, pats[p], "R5");
    // R6
    step(1, 16'hE3FF, 32'h3000, 4'h0, "R6");
    step(1, 16'hE400, 32'h3000, 4'hF, "R6");
    step(1, 16'hE7FF, 32'h3002, 4'h0, "R6");
    // R7
    step(1, 16'hDF2A, 32'h4000, 4'h0, "R7");
    // R8 clean pair and negative upper offset
    step(1, 16'hF001, 32'h5000, 4'h0, "R8");
    step(1, 16'hF805, 32'h5002, 4'h0, "R8");
    step(1, 16'hF7FF, 32'h6000, 4'h0, "R8");
    step(1, 16'hFFFF, 32'h6002, 4'h0, "R8");
    // R10 idle cycles keep pending
    step(1, 16'hF010, 32'h7000, 4'h0, "R10");
    step(0, 16'hF803, 32'h7002, 4'h0, "R10");
    step(0, 16'h0000, 32'h7002, 4'h0, "R10");
    step(1, 16'hF803, 32'h7002, 4'h0, "R10 R8");
    // R10 non-branch word cancels, R9 orphan follows
    step(1, 16'h2012, 32'h7100, 4'h0, "R10");
    step(1, 16'hF020, 32'h7102, 4'h0, "R10");
    step(1, 16'h2012, 32'h7104, 4'h0, "R10");
    step(1, 16'hF801, 32'h7106, 4'h0, "R9");
    step(1, 16'hF801, 32'h7108, 4'h0, "R9");
    // R11 back-to-back first words
    step(1, 16'hF100, 32'h8000, 4'h0, "R11");
    step(1, 16'hF002, 32'h8002, 4'h0, "R11");
    step(1, 16'hF804, 32'h8004, 4'h0, "R11");
    step(0, 16'h0000, '0, 4'h0, "R10");
    step(0, 16'h0000, '0, 4'h0, "R10");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule